// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Evaluator

This block decides which pins of an expander-style pin bank have an interrupt to report. Pins are grouped in banks of eight. For each bank it holds five configuration bytes: interrupt enable, rising-edge trigger, falling-edge trigger, high-level trigger and low-level trigger. It also keeps the last pin level it saw for that bank. Edge triggers are produced by comparing a fresh level byte against that stored level. Level triggers are ORed into the same result. The combined mask is then gated by a status byte that comes with the level, and by the bank's enable byte.

The caller offers one bank at a time: a bank index, the sampled level byte and the status byte. The block computes the pending mask in the cycle of acceptance and stores the new level as the bank's previous level. It then reports each pending pin as a global pin number, one per clock, lowest first. A done flag marks the final report of the evaluation. Configuration bytes are loaded through a write port that selects a field and a bank. A separate single-pin port turns one enable bit on or off and leaves every trigger setting alone.

Top module: `trig_irq_eval`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` and `out_done` are 0, and every configuration byte and stored level is 0. With all enables at 0, no pin is reported even when its level trigger matches.
- R2: A pin with its rising flag set is pending when its stored previous level is 0 and the new level is 1. It is not pending when the level stays at 1.
- R3: A pin with its falling flag set is pending when its stored previous level is 1 and the new level is 0. A rise on that pin does not make it pending unless its rising flag is also set.
- R4: A pin with both edge flags set is pending on every change of its level, in either direction.
- R5: A pin with its high flag set is pending on every evaluation where its level is 1. A pin with its low flag set is pending on every evaluation where its level is 0. Neither depends on the stored previous level.
- R6: A pin is reported only if its bit is 1 both in the status byte of that evaluation and in the bank's enable byte.
- R7: Each reported pin is given as `out_pin` = bank × 8 + bit position. The configuration field codes are: 0 enable, 1 rise, 2 fall, 3 high, 4 low, 5 stored-level seed. Codes 6 and 7 write nothing.
- R8: Pending pins are reported one per clock in ascending order with `out_valid` high. The first report comes in the cycle after the evaluation is accepted. `out_done` is high together with the last report.
- R9: When an evaluation yields no pending pin, the cycle after acceptance shows `out_done` high with `out_valid` low.
- R10: Each accepted evaluation replaces the bank's stored previous level with its level byte. A write with field code 5 sets the stored level directly.
- R11: A single-pin write (`pin_mask_we`, pin number `pin_mask_idx` = bank × 8 + bit) changes only that pin's enable bit. Its trigger flags are unchanged.
- R12: `in_ready` is 0 from the cycle after acceptance until the cycle after `out_done`. An `eval_valid` offered while `in_ready` is 0 is ignored and does not change the stored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_field | input | 3 | Field code (R7) |
| cfg_bank | input | BANK_W | Bank written |
| cfg_data | input | 8 | Byte written |
| pin_mask_we | input | 1 | Single-pin enable write strobe |
| pin_mask_idx | input | PIN_IDX_W | Global pin number of the single-pin write |
| pin_mask_en | input | 1 | New enable bit for that pin |
| eval_valid | input | 1 | Offer an evaluation |
| eval_bank | input | BANK_W | Bank to evaluate |
| eval_level | input | 8 | Sampled pin levels of the bank |
| eval_status | input | 8 | Status byte sampled with the levels |
| in_ready | output | 1 | Block can accept an evaluation |
| out_valid | output | 1 | `out_pin` holds a pending pin |
| out_pin | output | PIN_IDX_W | Global number of the pending pin |
| out_done | output | 1 | Last cycle of the current evaluation's report |

## Verification
A configuration write takes effect at the clock edge where it is sampled, so an evaluation offered in the next cycle already sees it. The pending mask is fixed at the acceptance edge. The first report, or the lone done cycle of an empty result, is therefore due one cycle after acceptance. The following reports come on consecutive cycles, and `in_ready` returns one cycle after `out_done`. The bench drives and samples on the falling edge and walks the expected pin list one falling edge at a time from the acceptance cycle, so each value is read in the exact cycle it is due.

// File: rtl/trig_eval_pkg.sv
package trig_eval_pkg;

    localparam int PINS_PER_BANK = 8;
    localparam int BIT_IDX_W     = $clog2(PINS_PER_BANK);

    typedef logic [PINS_PER_BANK-1:0] pin_byte_t;

    // Field codes of the configuration write port
    typedef enum logic [2:0] {
        FLD_ENABLE = 3'd0,
        FLD_RISE   = 3'd1,
        FLD_FALL   = 3'd2,
        FLD_HIGH   = 3'd3,
        FLD_LOW    = 3'd4,
        FLD_SEED   = 3'd5
    } cfg_field_e;

    typedef struct packed {
        pin_byte_t en;
        pin_byte_t rise;
        pin_byte_t fall;
        pin_byte_t high;
        pin_byte_t low;
        pin_byte_t prev;
    } bank_cfg_t;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } emit_state_e;

endpackage

// File: rtl/trig_cfg_store.sv
module trig_cfg_store
    import trig_eval_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_field,
    input  logic [BANK_W-1:0] cfg_bank,
    input  pin_byte_t         cfg_data,
    input  logic              pin_we,
    input  logic [BANK_W-1:0] pin_bank,
    input  logic [BIT_IDX_W-1:0] pin_bit,
    input  logic              pin_en,
    input  logic              upd_we,
    input  logic [BANK_W-1:0] upd_bank,
    input  pin_byte_t         upd_level,
    input  logic [BANK_W-1:0] rd_bank,
    output bank_cfg_t         rd_cfg
);

    typedef struct packed {
        bank_cfg_t [NUM_BANKS-1:0] banks;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (cfg_we) begin
            case (cfg_field)
                FLD_ENABLE: store_d.banks[cfg_bank].en   = cfg_data;
                FLD_RISE:   store_d.banks[cfg_bank].rise = cfg_data;
                FLD_FALL:   store_d.banks[cfg_bank].fall = cfg_data;
                FLD_HIGH:   store_d.banks[cfg_bank].high = cfg_data;
                FLD_LOW:    store_d.banks[cfg_bank].low  = cfg_data;
                FLD_SEED:   store_d.banks[cfg_bank].prev = cfg_data;
                default:    ;
            endcase
        end
        // single-pin enable edit touches one enable bit only
        if (pin_we) begin
            store_d.banks[pin_bank].en[pin_bit] = pin_en;
        end
        // an accepted evaluation records the level it saw
        if (upd_we) begin
            store_d.banks[upd_bank].prev = upd_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rd_cfg = store_q.banks[rd_bank];

endmodule

// File: rtl/trig_pending_calc.sv
module trig_pending_calc
    import trig_eval_pkg::*;
(
    input  pin_byte_t level,
    input  pin_byte_t status,
    input  bank_cfg_t cfg,
    output pin_byte_t pending
);

    for (genvar g = 0; g < PINS_PER_BANK; g++) begin : g_pin
        logic toggled;
        logic edge_hit;
        logic level_hit;

        always_comb begin
            toggled   = level[g] ^ cfg.prev[g];
            edge_hit  = toggled & ((cfg.rise[g] & level[g]) | (cfg.fall[g] & ~level[g]));
            level_hit = (cfg.high[g] & level[g]) | (cfg.low[g] & ~level[g]);
            pending[g] = (edge_hit | level_hit) & status[g] & cfg.en[g];
        end
    end

endmodule

// File: rtl/trig_pin_serializer.sv
module trig_pin_serializer
    import trig_eval_pkg::*;
#(
    parameter int BANK_W    = 2,
    localparam int PIN_IDX_W = BANK_W + BIT_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [BANK_W-1:0]    load_bank,
    input  pin_byte_t            load_mask,
    output logic                 idle,
    output logic                 out_valid,
    output logic [PIN_IDX_W-1:0] out_pin,
    output logic                 out_done
);

    typedef struct packed {
        emit_state_e       st;
        logic [BANK_W-1:0] bank;
        pin_byte_t         pend;
    } ser_t;

    ser_t ser_d, ser_q;
    logic [BIT_IDX_W-1:0] low_idx;
    logic                 several;

    always_comb begin
        low_idx = '0;
        for (int i = PINS_PER_BANK - 1; i >= 0; i--) begin
            if (ser_q.pend[i]) begin
                low_idx = BIT_IDX_W'(i);
            end
        end
        several = |(ser_q.pend & (ser_q.pend - pin_byte_t'(1)));

        ser_d = ser_q;
        case (ser_q.st)
            ST_IDLE: begin
                if (load) begin
                    ser_d.st   = ST_EMIT;
                    ser_d.bank = load_bank;
                    ser_d.pend = load_mask;
                end
            end
            default: begin
                ser_d.pend = ser_q.pend & (ser_q.pend - pin_byte_t'(1));
                if (!several) begin
                    ser_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ser_q <= ser_d;
        end
    end

    assign idle      = (ser_q.st == ST_IDLE);
    assign out_valid = (ser_q.st == ST_EMIT) && (|ser_q.pend);
    assign out_done  = (ser_q.st == ST_EMIT) && !several;
    assign out_pin   = {ser_q.bank, low_idx};

endmodule

// File: rtl/trig_irq_eval.sv
module trig_irq_eval
    import trig_eval_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int PIN_IDX_W = BANK_W + BIT_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_field,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic [7:0]           cfg_data,
    input  logic                 pin_mask_we,
    input  logic [PIN_IDX_W-1:0] pin_mask_idx,
    input  logic                 pin_mask_en,
    input  logic                 eval_valid,
    input  logic [BANK_W-1:0]    eval_bank,
    input  logic [7:0]           eval_level,
    input  logic [7:0]           eval_status,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [PIN_IDX_W-1:0] out_pin,
    output logic                 out_done
);

    logic      ser_idle;
    logic      accept;
    bank_cfg_t sel_cfg;
    pin_byte_t pend_mask;

    assign in_ready = ser_idle;
    assign accept   = eval_valid && ser_idle;

    trig_cfg_store #(.NUM_BANKS(NUM_BANKS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_field (cfg_field),
        .cfg_bank  (cfg_bank),
        .cfg_data  (cfg_data),
        .pin_we    (pin_mask_we),
        .pin_bank  (pin_mask_idx[PIN_IDX_W-1:BIT_IDX_W]),
        .pin_bit   (pin_mask_idx[BIT_IDX_W-1:0]),
        .pin_en    (pin_mask_en),
        .upd_we    (accept),
        .upd_bank  (eval_bank),
        .upd_level (eval_level),
        .rd_bank   (eval_bank),
        .rd_cfg    (sel_cfg)
    );

    trig_pending_calc u_calc (
        .level   (eval_level),
        .status  (eval_status),
        .cfg     (sel_cfg),
        .pending (pend_mask)
    );

    trig_pin_serializer #(.BANK_W(BANK_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_bank (eval_bank),
        .load_mask (pend_mask),
        .idle      (ser_idle),
        .out_valid (out_valid),
        .out_pin   (out_pin),
        .out_done  (out_done)
    );

endmodule

// File: rtl/trig_eval_checker.sv
module trig_eval_checker #(
    parameter int PIN_IDX_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 eval_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic [PIN_IDX_W-1:0] out_pin,
    input logic                 out_done
);

    // a report never appears while new work is accepted
    p_busy_while_report_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // acceptance makes the block busy in the next cycle
    p_accept_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid && in_ready) |=> !in_ready);

    // reports that are not the last are followed by a higher pin number
    p_ascending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_done) |=> (out_valid && (out_pin > $past(out_pin))));

    // a done cycle hands control back
    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> in_ready);

    // a busy cycle always shows a report or the closing done
    p_busy_productive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid || out_done));

endmodule

bind trig_irq_eval trig_eval_checker #(.PIN_IDX_W(PIN_IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_valid (eval_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_pin    (out_pin),
    .out_done   (out_done)
);

// File: tb/tb_trig_irq_eval.sv
module tb_trig_irq_eval;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int PIN_IDX_W = BANK_W + 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [2:0]           cfg_field = '0;
    logic [BANK_W-1:0]    cfg_bank = '0;
    logic [7:0]           cfg_data = '0;
    logic                 pin_mask_we = 1'b0;
    logic [PIN_IDX_W-1:0] pin_mask_idx = '0;
    logic                 pin_mask_en = 1'b0;
    logic                 eval_valid = 1'b0;
    logic [BANK_W-1:0]    eval_bank = '0;
    logic [7:0]           eval_level = '0;
    logic [7:0]           eval_status = '0;
    logic                 in_ready;
    logic                 out_valid;
    logic [PIN_IDX_W-1:0] out_pin;
    logic                 out_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    trig_irq_eval #(.NUM_BANKS(NUM_BANKS)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_field    (cfg_field),
        .cfg_bank     (cfg_bank),
        .cfg_data     (cfg_data),
        .pin_mask_we  (pin_mask_we),
        .pin_mask_idx (pin_mask_idx),
        .pin_mask_en  (pin_mask_en),
        .eval_valid   (eval_valid),
        .eval_bank    (eval_bank),
        .eval_level   (eval_level),
        .eval_status  (eval_status),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_pin      (out_pin),
        .out_done     (out_done)
    );

    task automatic check_eq(input int act, input int expv, input string req, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic write_cfg(input int field, input int bank, input logic [7:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_field = 3'(field);
        cfg_bank  = BANK_W'(bank);
        cfg_data  = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_pin(input int pin, input logic en);
        @(negedge clk);
        pin_mask_we  = 1'b1;
        pin_mask_idx = PIN_IDX_W'(pin);
        pin_mask_en  = en;
        @(negedge clk);
        pin_mask_we = 1'b0;
    endtask

    // Offer one evaluation and walk the expected report cycle by cycle
    task automatic run_eval(input int bank, input logic [7:0] lvl, input logic [7:0] sts,
                            input logic [7:0] exp_mask, input string req);
        int left;
        @(negedge clk);
        check_eq(int'(in_ready), 1, req, "ready before eval");
        eval_bank   = BANK_W'(bank);
        eval_level  = lvl;
        eval_status = sts;
        eval_valid  = 1'b1;
        @(negedge clk);
        eval_valid = 1'b0;
        if (exp_mask == 8'h00) begin
            check_eq(int'(out_valid), 0, req, "valid on empty result");
            check_eq(int'(out_done), 1, req, "done on empty result");
        end else begin
            left = $countones(exp_mask);
            for (int b = 0; b < 8; b++) begin
                if (exp_mask[b]) begin
                    left--;
                    check_eq(int'(out_valid), 1, req, "valid");
                    check_eq(int'(out_pin), bank * 8 + b, req, "pin number");
                    check_eq(int'(out_done), int'(left == 0), req, "done flag");
                    if (left != 0) @(negedge clk);
                end
            end
        end
        @(negedge clk);
        check_eq(int'(in_ready), 1, req, "ready after done");
        check_eq(int'(out_valid), 0, req, "valid after done");
    endtask

    task automatic test_reset();
        check_eq(int'(in_ready), 1, "R1", "reset ready");
        check_eq(int'(out_valid), 0, "R1", "reset valid");
        check_eq(int'(out_done), 0, "R1", "reset done");
    endtask

    task automatic test_enable_default();
        write_cfg(3, 0, 8'hFF);                         // high flags on, enables still 0
        run_eval(0, 8'hFF, 8'hFF, 8'h00, "R1");        // R9 empty result too
        write_cfg(3, 0, 8'h00);
        write_cfg(0, 0, 8'hFF);
        write_cfg(5, 0, 8'h00);
    endtask

    task automatic test_rise();
        write_cfg(1, 0, 8'h0F);
        run_eval(0, 8'h05, 8'hFF, 8'h05, "R2");
        run_eval(0, 8'h05, 8'hFF, 8'h00, "R10");       // stored level now 0x05
    endtask

    task automatic test_fall();
        write_cfg(2, 0, 8'hF0);
        run_eval(0, 8'hA0, 8'hFF, 8'h00, "R3");        // rises on fall-only pins
        run_eval(0, 8'h00, 8'hFF, 8'hA0, "R3");
    endtask

    task automatic test_both_edges();
        write_cfg(0, 1, 8'hFF);
        write_cfg(1, 1, 8'h81);
        write_cfg(2, 1, 8'h81);
        run_eval(1, 8'h81, 8'hFF, 8'h81, "R4");
        run_eval(1, 8'h01, 8'hFF, 8'h80, "R4");
        run_eval(1, 8'h00, 8'hFF, 8'h01, "R4");
        write_cfg(5, 1, 8'hFF);                         // seed stored level
        run_eval(1, 8'h00, 8'hFF, 8'h81, "R10");
        write_cfg(7, 1, 8'h00);                         // unused code writes nothing
        run_eval(1, 8'h81, 8'hFF, 8'h81, "R7");
    endtask

    task automatic test_levels();
        write_cfg(0, 2, 8'hFF);
        write_cfg(3, 2, 8'h03);
        write_cfg(4, 2, 8'h30);
        run_eval(2, 8'h01, 8'hFF, 8'h31, "R5");
        run_eval(2, 8'h01, 8'hFF, 8'h31, "R5");
    endtask

    task automatic test_gating();
        run_eval(2, 8'h01, 8'h11, 8'h11, "R6");
        write_cfg(0, 2, 8'h0F);
        run_eval(2, 8'h01, 8'hFF, 8'h01, "R6");
    endtask

    task automatic test_pin_mask();
        write_pin(21, 1'b1);                            // bank 2 bit 5 on
        run_eval(2, 8'h01, 8'hFF, 8'h21, "R11");
        write_pin(16, 1'b0);                            // bank 2 bit 0 off
        run_eval(2, 8'h01, 8'hFF, 8'h20, "R11");
    endtask

    task automatic test_busy_ignore();
        int left;
        write_cfg(0, 3, 8'hFF);
        write_cfg(3, 3, 8'hFF);
        @(negedge clk);
        eval_bank   = 2'd3;
        eval_level  = 8'hFF;
        eval_status = 8'hFF;
        eval_valid  = 1'b1;
        @(negedge clk);
        check_eq(int'(in_ready), 0, "R12", "ready while busy");
        eval_bank  = 2'd0;                              // offered while busy
        eval_level = 8'h05;
        left = 8;
        for (int b = 0; b < 8; b++) begin
            left--;
            check_eq(int'(out_valid), 1, "R8", "valid");
            check_eq(int'(out_pin), 24 + b, "R8", "pin order");
            check_eq(int'(out_done), int'(left == 0), "R8", "done flag");
            if (left == 0) eval_valid = 1'b0;
            else @(negedge clk);
        end
        @(negedge clk);
        check_eq(int'(out_valid), 0, "R12", "no report from ignored offer");
        check_eq(int'(out_done), 0, "R12", "no done from ignored offer");
        // bank 0 stored level must still be 0x00, so a rise on bits 0 and 2 shows
        run_eval(0, 8'h05, 8'hFF, 8'h05, "R12");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_enable_default();
        test_rise();
        test_fall();
        test_both_edges();
        test_levels();
        test_gating();
        test_pin_mask();
        test_busy_ignore();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule